// File: doc/BRIEF.md
# Auto Slot Identification Configuration Sequencer

This block is the controlling side of backplane auto slot identification. Every card that wants configuring holds a shared fail line while it gets ready, then raises a level-2 interrupt request and lets go of the fail line. A pulse on `start_i` arms the sequencer. It waits until the fail line has cleared, then moves the waiting cards one at a time. For each card it runs a single level-2 acknowledge and checks the returned vector. It then writes a fresh base address to configuration offset zero, which moves that card out of the shared slot.

Addresses are handed out from a programmable first value and grow by a programmable stride. An optional readback at the new address confirms that each move took effect. All bus traffic goes through a single-beat request/done handshake with three operations. A watchdog on every beat turns a missing done into a timeout error. When the pass ends, whether it finishes cleanly or stops on an error, the sequencer raises `done_o` with the card count and the error code. These outputs stay frozen until the next start pulse.

Top module: `slot_cfg_sequencer`

## Requirements
- R1: While the fail line input is high after a start pulse, no bus request is raised.
- R2: At most one card sits at offset zero. A new acknowledge (op 0) is only issued after the write that moves the previous card has completed.
- R3: An acknowledge whose returned data bits [7:0] differ from 0xFE ends the pass with error code 1 and no further bus request.
- R4: After a valid acknowledge, the next beat is a write (op 1) to address 0 that carries the new base address in the low data bits.
- R5: A new card step begins only while the level-2 request input is high. When it is low, the pass ends with error code 0, and the card count equals the number of completed relocation writes.
- R6: When verify is enabled at start, each relocation write is followed by a read (op 2) at the new base. If the returned low address bits differ from that base, the pass ends with error code 3.
- R7: The k-th card (counting from 0) receives base = first + k × stride, modulo the address width. Both values are latched at the start pulse.
- R8: If done does not arrive by the Nth cycle of a request (N = timeout limit latched at start, counting the cycle the request rises as the first), the request drops after exactly N cycles and the pass ends with error code 2.
- R9: `done_o` and `card_cnt_o` stay unchanged from the end of a pass until the next start pulse, whatever the interrupt line does. A start pulse clears `done_o`, the count and the error code.
- R10: A raised request holds its operation and address steady until done or a timeout.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | One-cycle pulse that starts a pass when idle or finished |
| verify_en_i | input | 1 | Enable readback after each relocation (latched at start) |
| first_base_i | input | ADDR_W | Base given to the first card (latched at start) |
| stride_i | input | ADDR_W | Increment between card bases (latched at start) |
| tmo_limit_i | input | TMO_W | Cycles allowed per bus beat (latched at start) |
| fail_line_i | input | 1 | Shared fail line, high while any card is not ready |
| irq_lvl2_i | input | 1 | Level-2 interrupt request line |
| bus_req_o | output | 1 | Bus beat request, held until done |
| bus_op_o | output | 2 | Beat type: 0 acknowledge, 1 write, 2 read |
| bus_addr_o | output | ADDR_W | Configuration address of the beat |
| bus_wdata_o | output | DATA_W | Write data (new base, zero-extended) |
| bus_rdata_i | input | DATA_W | Vector or read data, valid with done |
| bus_done_i | input | 1 | Beat complete, one cycle |
| done_o | output | 1 | Pass finished |
| card_cnt_o | output | CNT_W | Number of cards relocated in this pass |
| err_code_o | output | 2 | 0 none, 1 bad vector, 2 timeout, 3 readback mismatch |

## Verification
A request appears one cycle after the state change that causes it. The next beat, or the end of the pass, follows one edge after the done cycle. `done_o` rises two edges after the interrupt line is seen low: one edge to reach the polling step, one to finish. The bench acts as the backplane and its cards. It samples on the falling edge, so it judges each new request on its first cycle and each done on the cycle it is given, and it waits for `done_o` before comparing the count and error code. The timeout check counts the request cycles seen at the port and expects exactly the latched limit.

// File: rtl/slot_seq_pkg.sv
package slot_seq_pkg;

   typedef enum logic [1:0] {
      OP_IACK = 2'd0,
      OP_WR   = 2'd1,
      OP_RD   = 2'd2
   } bus_op_e;

   typedef enum logic [1:0] {
      ERR_NONE = 2'd0,
      ERR_VEC  = 2'd1,
      ERR_TMO  = 2'd2,
      ERR_RDBK = 2'd3
   } err_e;

   typedef enum logic [2:0] {
      S_IDLE,
      S_WAIT,
      S_POLL,
      S_IACK,
      S_WR,
      S_RD,
      S_END
   } seq_state_e;

endpackage

// File: rtl/slot_seq_timer.sv
module slot_seq_timer #(
   parameter int TMO_W      = 12,
   parameter bit TIMEOUT_EN = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run_i,
   input  logic             hit_i,
   input  logic [TMO_W-1:0] limit_i,
   output logic             expired_o
);

   if (TMO_W < 2) begin : g_bad_w
      $error("slot_seq_timer: TMO_W must be at least 2");
   end

   if (TIMEOUT_EN) begin : g_tmo
      logic [TMO_W-1:0] cnt_q;
      logic [TMO_W:0]   used_w;

      assign used_w    = {1'b0, cnt_q} + {{TMO_W{1'b0}}, 1'b1};
      assign expired_o = run_i && !hit_i && (used_w >= {1'b0, limit_i});

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                cnt_q <= '0;
         else if (!run_i || hit_i)  cnt_q <= '0;
         else if (!expired_o)       cnt_q <= cnt_q + 1'b1;
      end

      // R8
      cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (run_i && !hit_i && !expired_o) |=> (cnt_q == $past(cnt_q) + 1'b1));
   end else begin : g_none
      logic unused_in;
      assign unused_in = ^{run_i, hit_i, limit_i};
      assign expired_o = 1'b0;
   end

endmodule

// File: rtl/slot_seq_addr.sv
module slot_seq_addr #(
   parameter int ADDR_W = 24
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load_i,
   input  logic [ADDR_W-1:0] first_i,
   input  logic [ADDR_W-1:0] stride_i,
   input  logic              step_i,
   output logic [ADDR_W-1:0] base_o
);

   logic [ADDR_W-1:0] stride_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         base_o   <= '0;
         stride_q <= '0;
      end else if (load_i) begin
         base_o   <= first_i;
         stride_q <= stride_i;
      end else if (step_i) begin
         base_o   <= base_o + stride_q;
      end
   end

   // R7
   base_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (step_i && !load_i) |=> (base_o == $past(base_o + stride_q)));

endmodule

// File: rtl/slot_cfg_sequencer.sv
module slot_cfg_sequencer
   import slot_seq_pkg::*;
#(
   parameter int          ADDR_W     = 24,
   parameter int          DATA_W     = 32,
   parameter int          CNT_W      = 5,
   parameter int          TMO_W      = 12,
   parameter bit          TIMEOUT_EN = 1'b1,
   parameter logic [7:0]  VEC_CODE   = 8'hFE
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_i,
   input  logic              verify_en_i,
   input  logic [ADDR_W-1:0] first_base_i,
   input  logic [ADDR_W-1:0] stride_i,
   input  logic [TMO_W-1:0]  tmo_limit_i,
   input  logic              fail_line_i,
   input  logic              irq_lvl2_i,
   output logic              bus_req_o,
   output logic [1:0]        bus_op_o,
   output logic [ADDR_W-1:0] bus_addr_o,
   output logic [DATA_W-1:0] bus_wdata_o,
   input  logic [DATA_W-1:0] bus_rdata_i,
   input  logic              bus_done_i,
   output logic              done_o,
   output logic [CNT_W-1:0]  card_cnt_o,
   output logic [1:0]        err_code_o
);

   if (DATA_W < ADDR_W || DATA_W < 8) begin : g_bad_dw
      $error("slot_cfg_sequencer: DATA_W must cover ADDR_W and a vector byte");
   end
   if (CNT_W < 1 || ADDR_W < 1) begin : g_bad_cw
      $error("slot_cfg_sequencer: CNT_W and ADDR_W must be positive");
   end

   seq_state_e        state_q;
   logic              verify_q;
   logic [TMO_W-1:0]  lim_q;
   logic              at_zero_q;
   logic              tmo_w;
   logic              step_w;
   logic              load_w;
   logic              vec_ok_w;
   logic              rdbk_ok_w;
   logic [ADDR_W-1:0] base_w;

   assign load_w    = start_i && (state_q == S_IDLE || state_q == S_END);
   assign vec_ok_w  = (bus_rdata_i[7:0] == VEC_CODE);
   assign rdbk_ok_w = (bus_rdata_i[ADDR_W-1:0] == base_w);
   assign step_w    = bus_done_i &&
                      ((state_q == S_WR && !verify_q) || (state_q == S_RD && rdbk_ok_w));

   slot_seq_addr #(.ADDR_W(ADDR_W)) u_addr (
      .clk      (clk),
      .rst_n    (rst_n),
      .load_i   (load_w),
      .first_i  (first_base_i),
      .stride_i (stride_i),
      .step_i   (step_w),
      .base_o   (base_w)
   );

   slot_seq_timer #(.TMO_W(TMO_W), .TIMEOUT_EN(TIMEOUT_EN)) u_timer (
      .clk       (clk),
      .rst_n     (rst_n),
      .run_i     (bus_req_o),
      .hit_i     (bus_done_i),
      .limit_i   (lim_q),
      .expired_o (tmo_w)
   );

   always_comb begin
      bus_req_o   = 1'b0;
      bus_op_o    = OP_IACK;
      bus_addr_o  = '0;
      bus_wdata_o = DATA_W'(base_w);
      unique case (state_q)
         S_IACK: begin
            bus_req_o = 1'b1;
            bus_op_o  = OP_IACK;
         end
         S_WR: begin
            bus_req_o = 1'b1;
            bus_op_o  = OP_WR;
         end
         S_RD: begin
            bus_req_o  = 1'b1;
            bus_op_o   = OP_RD;
            bus_addr_o = base_w;
         end
         default: ;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q    <= S_IDLE;
         verify_q   <= 1'b0;
         lim_q      <= '0;
         at_zero_q  <= 1'b0;
         done_o     <= 1'b0;
         card_cnt_o <= '0;
         err_code_o <= ERR_NONE;
      end else begin
         unique case (state_q)
            S_IDLE, S_END: begin
               if (load_w) begin
                  state_q    <= S_WAIT;
                  verify_q   <= verify_en_i;
                  lim_q      <= tmo_limit_i;
                  at_zero_q  <= 1'b0;
                  done_o     <= 1'b0;
                  card_cnt_o <= '0;
                  err_code_o <= ERR_NONE;
               end
            end
            S_WAIT: begin
               if (!fail_line_i) state_q <= S_POLL;
            end
            S_POLL: begin
               if (irq_lvl2_i) begin
                  state_q <= S_IACK;
               end else begin
                  state_q <= S_END;
                  done_o  <= 1'b1;
               end
            end
            S_IACK: begin
               if (bus_done_i) begin
                  if (vec_ok_w) begin
                     state_q   <= S_WR;
                     at_zero_q <= 1'b1;
                  end else begin
                     state_q    <= S_END;
                     done_o     <= 1'b1;
                     err_code_o <= ERR_VEC;
                  end
               end else if (tmo_w) begin
                  state_q    <= S_END;
                  done_o     <= 1'b1;
                  err_code_o <= ERR_TMO;
               end
            end
            S_WR: begin
               if (bus_done_i) begin
                  at_zero_q  <= 1'b0;
                  card_cnt_o <= card_cnt_o + 1'b1;
                  state_q    <= verify_q ? S_RD : S_POLL;
               end else if (tmo_w) begin
                  state_q    <= S_END;
                  done_o     <= 1'b1;
                  err_code_o <= ERR_TMO;
               end
            end
            S_RD: begin
               if (bus_done_i) begin
                  if (rdbk_ok_w) begin
                     state_q <= S_POLL;
                  end else begin
                     state_q    <= S_END;
                     done_o     <= 1'b1;
                     err_code_o <= ERR_RDBK;
                  end
               end else if (tmo_w) begin
                  state_q    <= S_END;
                  done_o     <= 1'b1;
                  err_code_o <= ERR_TMO;
               end
            end
            default: state_q <= S_IDLE;
         endcase
      end
   end

   // R1
   wait_fail_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == S_WAIT && fail_line_i) |=> !bus_req_o);

   // R2
   ack_serial_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_req_o && bus_op_o == OP_IACK) |-> !at_zero_q);

   // R3
   bad_vec_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_req_o && bus_op_o == OP_IACK && bus_done_i && !vec_ok_w)
      |=> (done_o && err_code_o == ERR_VEC && !bus_req_o));

   // R5
   cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_req_o && bus_op_o == OP_WR && bus_done_i)
      |=> (card_cnt_o == $past(card_cnt_o) + 1'b1));

   // R8
   tmo_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      tmo_w |=> (done_o && err_code_o == ERR_TMO && !bus_req_o));

   // R9
   done_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (done_o && !start_i) |=> (done_o && $stable(card_cnt_o) && $stable(err_code_o)));

   // R10
   req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_req_o && !bus_done_i && !tmo_w)
      |=> (bus_req_o && $stable(bus_op_o) && $stable(bus_addr_o)));

endmodule

// File: tb/sim_slot_cfg_sequencer.sv
module sim_slot_cfg_sequencer;

   localparam int AW = 24;
   localparam int DW = 32;
   localparam int CW = 5;
   localparam int TW = 12;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          start_i = 1'b0;
   logic          verify_en_i = 1'b0;
   logic [AW-1:0] first_base_i = '0;
   logic [AW-1:0] stride_i = '0;
   logic [TW-1:0] tmo_limit_i = '0;
   logic          fail_line_i = 1'b1;
   logic          irq_lvl2_i;
   logic          bus_req_o;
   logic [1:0]    bus_op_o;
   logic [AW-1:0] bus_addr_o;
   logic [DW-1:0] bus_wdata_o;
   logic [DW-1:0] bus_rdata_i;
   logic          bus_done_i;
   logic          done_o;
   logic [CW-1:0] card_cnt_o;
   logic [1:0]    err_code_o;

   always #4 clk = ~clk;

   slot_cfg_sequencer u0 (
      .clk(clk), .rst_n(rst_n), .start_i(start_i), .verify_en_i(verify_en_i),
      .first_base_i(first_base_i), .stride_i(stride_i), .tmo_limit_i(tmo_limit_i),
      .fail_line_i(fail_line_i), .irq_lvl2_i(irq_lvl2_i), .bus_req_o(bus_req_o),
      .bus_op_o(bus_op_o), .bus_addr_o(bus_addr_o), .bus_wdata_o(bus_wdata_o),
      .bus_rdata_i(bus_rdata_i), .bus_done_i(bus_done_i), .done_o(done_o),
      .card_cnt_o(card_cnt_o), .err_code_o(err_code_o)
   );

   int n_tests = 0;
   int n_fail  = 0;

   // backplane model
   int            card_vec[$];
   int            card_delay = 1;
   int            hang_op = -1;
   int            rd_corrupt = 0;
   int            at_zero = 0;
   int            n_acks = 0;
   int            n_written = 0;
   int            wcnt = 0;
   int            last_run = 0;
   logic [AW-1:0] exp_base = '0;
   logic [AW-1:0] step_val = '0;
   logic [AW-1:0] written_base = '0;

   task automatic chk(input bit ok, input string rq, input string what,
                      input longint act, input longint exp);
      n_tests++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual 0x%0h expected 0x%0h", rq, what, act, exp);
      end
   endtask

   initial begin
      bus_done_i  = 1'b0;
      bus_rdata_i = '0;
      irq_lvl2_i  = 1'b0;
      forever begin
         @(negedge clk);
         bus_done_i  = 1'b0;
         bus_rdata_i = '0;
         if (bus_req_o) begin
            wcnt++;
            if (done_o) chk(0, "R9", "request while finished", 1, 0);
            if (wcnt == 1) begin
               case (bus_op_o)
                  2'd0: begin
                     chk(fail_line_i == 1'b0, "R1", "ack with fail line high", fail_line_i, 0);
                     chk(at_zero == 0, "R2", "ack while a card sits at offset 0", at_zero, 0);
                  end
                  2'd1: begin
                     chk(bus_addr_o == '0, "R4", "relocation write address", bus_addr_o, 0);
                     chk(bus_wdata_o == DW'(exp_base), "R7", "assigned base", bus_wdata_o, exp_base);
                  end
                  2'd2: chk(bus_addr_o == written_base, "R6", "readback address", bus_addr_o, written_base);
                  default: chk(0, "R10", "illegal op", bus_op_o, 0);
               endcase
            end
            if (hang_op != int'(bus_op_o) && wcnt >= card_delay) begin
               bus_done_i = 1'b1;
               wcnt = 0;
               case (bus_op_o)
                  2'd0: begin
                     int v;
                     v = (card_vec.size() > 0) ? card_vec.pop_front() : 0;
                     bus_rdata_i = DW'(v);
                     at_zero = (v == 'hFE) ? 1 : 0;
                     n_acks++;
                  end
                  2'd1: begin
                     at_zero = 0;
                     written_base = bus_wdata_o[AW-1:0];
                     exp_base = exp_base + step_val;
                     n_written++;
                  end
                  default: bus_rdata_i = DW'(written_base) ^ DW'(rd_corrupt);
               endcase
            end
         end else begin
            if (wcnt > 0) last_run = wcnt;
            wcnt = 0;
         end
         irq_lvl2_i = (card_vec.size() != 0);
      end
   end

   initial begin
      repeat (150000) @(posedge clk);
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: run did not finish");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   task automatic run_pass(input int ncards, input int bad_idx, input int dly,
                           input int hop, input bit ver, input int corrupt,
                           input int hold, input int first, input int stride,
                           input int tmo);
      card_vec.delete();
      for (int i = 0; i < ncards; i++) card_vec.push_back(i == bad_idx ? 'h5A : 'hFE);
      card_delay = dly; hang_op = hop; rd_corrupt = corrupt;
      at_zero = 0; n_acks = 0; n_written = 0; last_run = 0;
      exp_base = AW'(first); step_val = AW'(stride);
      first_base_i = AW'(first); stride_i = AW'(stride);
      tmo_limit_i = TW'(tmo); verify_en_i = ver;
      fail_line_i = 1'b1;
      @(negedge clk); @(negedge clk);
      start_i = 1'b1;
      @(negedge clk);
      start_i = 1'b0;
      chk(done_o == 1'b0, "R9", "done cleared by start", done_o, 0);
      for (int i = 0; i < hold; i++) begin
         @(negedge clk);
         chk(bus_req_o == 1'b0, "R1", "request during fail hold", bus_req_o, 0);
      end
      fail_line_i = 1'b0;
      for (int i = 0; i < 4000 && !done_o; i++) @(negedge clk);
      chk(done_o == 1'b1, "R5", "pass finished", done_o, 1);
      chk(bus_req_o == 1'b0, "R3", "bus idle after finish", bus_req_o, 0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      chk(done_o == 0 && bus_req_o == 0, "R9", "reset done/req", {done_o, bus_req_o}, 0);
      chk(card_cnt_o == 0 && err_code_o == 0, "R5", "reset count/err", {card_cnt_o, err_code_o}, 0);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);

      // three cards, no readback, fail line held 20 cycles
      run_pass(3, -1, 1, -1, 1'b0, 0, 20, 'h1000, 'h100, 16);
      chk(card_cnt_o == 3, "R5", "count of three", card_cnt_o, 3);
      chk(err_code_o == 0, "R5", "clean end", err_code_o, 0);
      chk(n_written == 3 && n_acks == 3, "R2", "one write per ack", n_written, 3);
      chk(written_base == 'h1200, "R7", "last base", written_base, 'h1200);
      // R9: line rises again after the pass; outputs must hold, no request
      card_vec.push_back('hFE);
      for (int i = 0; i < 15; i++) begin
         @(negedge clk);
         chk(done_o == 1 && card_cnt_o == 3 && !bus_req_o, "R9", "held after finish",
             {done_o, card_cnt_o}, {1'b1, 5'd3});
      end
      card_vec.delete();

      // no cards present
      run_pass(0, -1, 1, -1, 1'b0, 0, 2, 'h2000, 'h10, 16);
      chk(card_cnt_o == 0 && n_acks == 0, "R5", "empty backplane", card_cnt_o, 0);
      chk(err_code_o == 0, "R5", "empty clean end", err_code_o, 0);

      // four cards with readback, done on the last allowed cycle
      run_pass(4, -1, 3, -1, 1'b1, 0, 5, 'hFFFF00, 'h80, 3);
      chk(card_cnt_o == 4, "R6", "count with readback", card_cnt_o, 4);
      chk(err_code_o == 0, "R8", "done on last allowed cycle", err_code_o, 0);
      chk(written_base == 'h000080, "R7", "base wraps at address width", written_base, 'h80);

      // second card returns a wrong vector
      run_pass(3, 1, 2, -1, 1'b0, 0, 1, 'h4000, 'h40, 16);
      chk(err_code_o == 1, "R3", "bad vector error", err_code_o, 1);
      chk(card_cnt_o == 1 && n_written == 1, "R3", "stop after bad vector", n_written, 1);

      // write never completes
      run_pass(2, -1, 1, 1, 1'b0, 0, 1, 'h5000, 'h10, 8);
      chk(err_code_o == 2, "R8", "timeout error", err_code_o, 2);
      chk(card_cnt_o == 0, "R8", "no card counted", card_cnt_o, 0);
      chk(last_run == 8, "R8", "request length at timeout", last_run, 8);

      // readback returns a wrong value
      run_pass(2, -1, 1, -1, 1'b1, 4, 1, 'h6000, 'h100, 16);
      chk(err_code_o == 3, "R6", "readback mismatch", err_code_o, 3);
      chk(card_cnt_o == 1 && n_acks == 1, "R6", "stop after mismatch", card_cnt_o, 1);

      // long done delay: request held steady
      run_pass(1, -1, 6, -1, 1'b0, 0, 1, 'h7000, 'h1, 16);
      chk(card_cnt_o == 1 && err_code_o == 0, "R10", "slow bus completes", card_cnt_o, 1);

      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

endmodule